// File: doc/BRIEF.md
# Register Bank Subordinate with Two-Cycle Error Response

This block is a small word-addressed register bank that sits on a pipelined, AHB-Lite style bus as a subordinate. A manager presents a transfer in an address phase. When the bus ready input is high, the block captures that phase and then answers in the following data phase. That answer can be a number of fixed wait states, an OKAY completion with read data or a write update, or a two-cycle ERROR response.

The two-cycle ERROR response gives the manager a cycle to react. It can withdraw the transfer it is already presenting by driving IDLE, or it can keep that transfer on the bus. A withdrawn transfer costs nothing: an IDLE transfer seen on the accepting edge performs no operation. A transfer that is kept is accepted on the edge that completes the error and then runs like any other transfer.

The block returns an error in two cases: any access to a configurable band of byte addresses, and any write to the words at the bottom of the bank, which are constants. An erroring write leaves storage unchanged and an erroring read returns zero data. Word selection uses the address bits just above the byte offset, so addresses above the bank alias onto it.

Top module: `ahb_err_sub`

## Requirements
- R1: While reset is held and right after it is released, hreadyout is 1, hresp is 0 and hrdata is zero.
- R2: A transfer with htrans IDLE (00) or BUSY (01), or with hsel low, that is accepted is answered in the next cycle with hreadyout 1 and hresp 0, and it changes no stored word.
- R3: An accepted NONSEQ (10) or SEQ (11) transfer is followed by exactly WAIT_STATES cycles with hreadyout 0 and hresp 0 before its response begins (default 1).
- R4: An error response starts with one cycle in which hresp is 1 and hreadyout is 0.
- R5: The cycle after the first error cycle always has hresp 1 and hreadyout 1, which ends the transfer.
- R6: Any transfer whose byte address lies in ILL_LO..ILL_HI inclusive (default 0x28..0x2F) gets an error response.
- R7: Words 0..RO_WORDS-1 (default 0..3) are read-only and hold RO_PATTERN + index (default 0xC0DE0000 + index). A write to one of them gets an error response and leaves it unchanged.
- R8: During both error cycles hrdata is zero, and an erroring write changes no stored word.
- R9: While hready is low, the block captures no address phase. A transfer presented in such a cycle has no effect.
- R10: If the manager presents a valid transfer through an error, that transfer is accepted on the edge that completes the error and is processed normally.
- R11: hresp returns to 0 in the cycle after an error completes, unless that cycle is the first cycle of another error.
- R12: An OKAY write stores hwdata into word haddr[5:2] on the edge that ends its data phase. An OKAY read drives that word on hrdata in its completion cycle, so addresses differing only above bit 5 reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Subordinate select for the address phase |
| haddr | input | ADDR_W | Byte address of the address phase |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hwrite | input | 1 | 1 for write, 0 for read |
| hready | input | 1 | Bus ready; an address phase is captured only when high |
| hwdata | input | DATA_W | Write data for the current data phase |
| hreadyout | output | 1 | Low to extend the current data phase |
| hresp | output | 1 | 1 signals ERROR, 0 signals OKAY |
| hrdata | output | DATA_W | Read data, valid in an OKAY read completion cycle |

## Verification
The assertions assume that hready is high whenever a data phase of this block finishes, as it is when the block is the only subordinate and its hreadyout is looped back. They also assume that the manager holds its address phase while hreadyout is low, except that it may switch to IDLE in the first error cycle. The stimulus follows these rules. It drives hready from the expected ready value and pulls it low only when no data phase of this block is pending. During wait states it repeats the last transfer. In the first error cycle it either cancels to IDLE or keeps the transfer, chosen at random.

// File: rtl/ahb_sub_pkg.sv
package ahb_sub_pkg;

   // data-phase states of the subordinate
   typedef enum logic [1:0] {
      ST_OKAY = 2'd0,   // idle or OKAY completion, ready high
      ST_WAIT = 2'd1,   // inserted wait state, ready low
      ST_ERR1 = 2'd2,   // first error cycle, ready low
      ST_ERR2 = 2'd3    // second error cycle, ready high
   } dp_state_e;

   localparam logic [1:0] TR_IDLE   = 2'b00;
   localparam logic [1:0] TR_BUSY   = 2'b01;
   localparam logic [1:0] TR_NONSEQ = 2'b10;
   localparam logic [1:0] TR_SEQ    = 2'b11;

   function automatic logic is_active(input logic [1:0] tr);
      return (tr == TR_NONSEQ) || (tr == TR_SEQ);
   endfunction

endpackage

// File: rtl/ahb_sub_decode.sv
module ahb_sub_decode #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned IDX_W    = 4,
   parameter int unsigned RO_WORDS = 4,
   parameter int unsigned ILL_LO   = 'h28,
   parameter int unsigned ILL_HI   = 'h2F
) (
   input  logic [ADDR_W-1:0] haddr,
   input  logic              hwrite,
   output logic [IDX_W-1:0]  idx,
   output logic              err
);

   logic in_band;
   logic ro_hit;

   assign idx     = haddr[IDX_W+1:2];
   assign in_band = (haddr >= ADDR_W'(ILL_LO)) && (haddr <= ADDR_W'(ILL_HI));

   generate
      if (RO_WORDS == 0) begin : g_no_ro
         assign ro_hit = 1'b0;
      end else begin : g_ro
         assign ro_hit = ({1'b0, idx} < (IDX_W+1)'(RO_WORDS));
      end
   endgenerate

   assign err = in_band || (hwrite && ro_hit);

endmodule

// File: rtl/ahb_sub_regbank.sv
module ahb_sub_regbank #(
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       NUM_WORDS  = 16,
   parameter int unsigned       RO_WORDS   = 4,
   parameter logic [DATA_W-1:0] RO_PATTERN = '0,
   localparam int unsigned      IDX_W      = $clog2(NUM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [NUM_WORDS-1:0][DATA_W-1:0] words;

   generate
      for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
         if (i < RO_WORDS) begin : g_const
            assign words[i] = RO_PATTERN + DATA_W'(i);
         end else begin : g_flop
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= '0;
               else if (wr_en && (wr_idx == IDX_W'(i)))
                  q <= wr_data;
            end
            assign words[i] = q;
         end
      end
   endgenerate

   assign rd_data = words[rd_idx];

   generate
      if (RO_WORDS > 0) begin : g_ro_chk
         // R7: no write strobe ever reaches a constant word
         p_ro_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> ({1'b0, wr_idx} >= (IDX_W+1)'(RO_WORDS)));
      end
   endgenerate

endmodule

// File: rtl/ahb_sub_dpctl.sv
module ahb_sub_dpctl
   import ahb_sub_pkg::*;
#(
   parameter int unsigned WAIT_STATES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hready,
   input  logic req_valid,
   input  logic req_err,
   output logic hreadyout,
   output logic hresp
);

   localparam bit HAS_WAIT = (WAIT_STATES > 0);

   dp_state_e st, st_nx;
   logic      acc;
   logic      pend_err;
   logic      wait_last;

   assign hreadyout = (st == ST_OKAY) || (st == ST_ERR2);
   assign hresp     = (st == ST_ERR1) || (st == ST_ERR2);
   assign acc       = hready && hreadyout;

   generate
      if (HAS_WAIT) begin : g_wait
         localparam int unsigned CNT_W = $clog2(WAIT_STATES + 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (acc && req_valid)
               cnt <= CNT_W'(WAIT_STATES - 1);
            else if ((st == ST_WAIT) && (cnt != '0))
               cnt <= cnt - 1'b1;
         end
         assign wait_last = (cnt == '0);
      end else begin : g_nowait
         assign wait_last = 1'b1;
      end
   endgenerate

   always_comb begin
      st_nx = ST_OKAY;
      case (st)
         ST_WAIT: begin
            if (wait_last)
               st_nx = pend_err ? ST_ERR1 : ST_OKAY;
            else
               st_nx = ST_WAIT;
         end
         ST_ERR1: st_nx = ST_ERR2;
         default: begin
            if (acc && req_valid) begin
               if (HAS_WAIT)
                  st_nx = ST_WAIT;
               else
                  st_nx = req_err ? ST_ERR1 : ST_OKAY;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_OKAY;
         pend_err <= 1'b0;
      end else begin
         st <= st_nx;
         if (acc)
            pend_err <= req_valid && req_err;
      end
   end

   // R2: a no-operation transfer gets a zero-wait OKAY
   p_idle_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !req_valid) |=> (hreadyout && !hresp));

   // R4: an error always opens with ready low
   p_err_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hresp) |-> !hreadyout);

   // R5: first error cycle is always followed by the completing one
   p_err_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hresp && !hreadyout) |=> (hresp && hreadyout));

   // R11: the error indication is released after completion
   p_resp_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (hresp && hreadyout && !(acc && req_valid && req_err)) |=> !hresp);

   generate
      if (HAS_WAIT) begin : g_wait_chk
         // R3: an accepted transfer starts with an OKAY wait state
         p_wait_okay_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (acc && req_valid) |=> (!hreadyout && !hresp));
      end
   endgenerate

endmodule

// File: rtl/ahb_err_sub.sv
module ahb_err_sub
   import ahb_sub_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 8,
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       NUM_WORDS   = 16,
   parameter int unsigned       RO_WORDS    = 4,
   parameter int unsigned       ILL_LO      = 'h28,
   parameter int unsigned       ILL_HI      = 'h2F,
   parameter int unsigned       WAIT_STATES = 1,
   parameter logic [DATA_W-1:0] RO_PATTERN  = DATA_W'(32'hC0DE_0000)
) (
   input  logic              hclk,
   input  logic              hresetn,
   input  logic              hsel,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [1:0]        htrans,
   input  logic              hwrite,
   input  logic              hready,
   input  logic [DATA_W-1:0] hwdata,
   output logic              hreadyout,
   output logic              hresp,
   output logic [DATA_W-1:0] hrdata
);

   localparam int unsigned IDX_W = $clog2(NUM_WORDS);

   // elaboration-time parameter checks
   generate
      if (NUM_WORDS < 2 || (1 << IDX_W) != NUM_WORDS) begin : g_bad_depth
         $error("NUM_WORDS must be a power of two, at least 2");
      end
      if (ADDR_W < IDX_W + 2) begin : g_bad_addr
         $error("ADDR_W too narrow for NUM_WORDS");
      end
      if (RO_WORDS > NUM_WORDS) begin : g_bad_ro
         $error("RO_WORDS exceeds NUM_WORDS");
      end
      if (ILL_LO > ILL_HI) begin : g_bad_band
         $error("ILL_LO must not exceed ILL_HI");
      end
      if (DATA_W == 0 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("DATA_W must be a nonzero multiple of 8");
      end
   endgenerate

   logic             req_valid;
   logic             req_err;
   logic [IDX_W-1:0] req_idx;

   logic             dp_valid;
   logic             dp_write;
   logic             dp_err;
   logic [IDX_W-1:0] dp_idx;

   logic              wr_en;
   logic              okay_done;
   logic [DATA_W-1:0] rd_word;

   assign req_valid = hsel && is_active(htrans);

   ahb_sub_decode #(
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W),
      .RO_WORDS (RO_WORDS),
      .ILL_LO   (ILL_LO),
      .ILL_HI   (ILL_HI)
   ) u_decode (
      .haddr  (haddr),
      .hwrite (hwrite),
      .idx    (req_idx),
      .err    (req_err)
   );

   ahb_sub_dpctl #(
      .WAIT_STATES (WAIT_STATES)
   ) u_dpctl (
      .clk       (hclk),
      .rst_n     (hresetn),
      .hready    (hready),
      .req_valid (req_valid),
      .req_err   (req_err),
      .hreadyout (hreadyout),
      .hresp     (hresp)
   );

   // address-phase capture: only when the previous phase is over
   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         dp_valid <= 1'b0;
         dp_write <= 1'b0;
         dp_err   <= 1'b0;
         dp_idx   <= '0;
      end else if (hreadyout) begin
         if (hready) begin
            dp_valid <= req_valid;
            dp_write <= hwrite;
            dp_err   <= req_err;
            dp_idx   <= req_idx;
         end else begin
            dp_valid <= 1'b0;
         end
      end
   end

   assign okay_done = hreadyout && !hresp && dp_valid;
   assign wr_en     = okay_done && dp_write && !dp_err;

   ahb_sub_regbank #(
      .DATA_W     (DATA_W),
      .NUM_WORDS  (NUM_WORDS),
      .RO_WORDS   (RO_WORDS),
      .RO_PATTERN (RO_PATTERN)
   ) u_bank (
      .clk     (hclk),
      .rst_n   (hresetn),
      .wr_en   (wr_en),
      .wr_idx  (dp_idx),
      .wr_data (hwdata),
      .rd_idx  (dp_idx),
      .rd_data (rd_word)
   );

   assign hrdata = (okay_done && !dp_write) ? rd_word : '0;

   // R8: no data leaks out during an error response
   p_err_rdata_zero_r8: assert property (@(posedge hclk) disable iff (!hresetn)
      hresp |-> (hrdata == '0));

   // R9: with bus ready low nothing is captured, so the block stays idle
   p_no_capture_r9: assert property (@(posedge hclk) disable iff (!hresetn)
      (hreadyout && !hresp && !hready) |=> (hreadyout && !hresp));

   // R1: reset value of the response
   always_comb begin
      if (!hresetn) begin
         a_reset_idle_r1: assert (hreadyout && !hresp);
      end
   end

endmodule

// File: tb/ahb_err_sub_tb.sv
`timescale 1ns/1ps
module ahb_err_sub_tb_top;

   localparam int          WAITS = 1;
   localparam logic [31:0] PAT   = 32'hC0DE_0000;
   localparam int          NRAND = 4000;

   logic        hclk = 1'b0;
   logic        hresetn = 1'b0;
   logic        hsel = 1'b0;
   logic [7:0]  haddr = '0;
   logic [1:0]  htrans = 2'b00;
   logic        hwrite = 1'b0;
   logic        hready = 1'b1;
   logic [31:0] hwdata = '0;
   logic        hreadyout;
   logic        hresp;
   logic [31:0] hrdata;

   always #2.5 hclk = ~hclk;

   ahb_err_sub dut_i (
      .hclk      (hclk),
      .hresetn   (hresetn),
      .hsel      (hsel),
      .haddr     (haddr),
      .htrans    (htrans),
      .hwrite    (hwrite),
      .hready    (hready),
      .hwdata    (hwdata),
      .hreadyout (hreadyout),
      .hresp     (hresp),
      .hrdata    (hrdata)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // reference model of the requirements
   int          m_st = 0;      // 0 okay, 1 wait, 2 err first, 3 err second
   int          m_cnt = 0;
   bit          m_valid = 0, m_write = 0, m_err = 0;
   int          m_idx = 0;
   logic [31:0] m_wd = '0;
   logic [31:0] mem [16];

   // last driven address phase
   bit          d_sel = 0, d_wr = 0;
   logic [1:0]  d_tr = 2'b00;
   logic [7:0]  d_ad = '0;
   logic [31:0] d_wd = '0;

   function automatic bit exp_ready();
      return (m_st == 0) || (m_st == 3);
   endfunction
   function automatic bit exp_resp();
      return m_st >= 2;
   endfunction
   function automatic logic [31:0] exp_rdata();
      if (m_st == 0 && m_valid && !m_write) return mem[m_idx];
      return 32'h0;
   endfunction
   function automatic bit addr_err(input logic [7:0] a, input bit w);
      int ix = (int'(a) >> 2) & 15;
      return (a >= 8'h28 && a <= 8'h2F) || (w && ix < 4);
   endfunction
   function automatic string tag_now();
      case (m_st)
         1: return "R3";
         2: return "R4";
         3: return "R5";
         default: return (m_valid && !m_write) ? "R12" : "R2";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic auto_check();
      chk(tag_now(), {29'd0, hreadyout, hresp, |hrdata},
          {29'd0, exp_ready(), exp_resp(), |exp_rdata()});
      chk(tag_now(), hrdata, exp_rdata());
   endtask

   task automatic model_step(input bit s, input logic [1:0] t, input bit w,
                             input logic [7:0] a, input logic [31:0] wd, input bit hr);
      bit acc;
      if (m_st == 0 && m_valid && m_write && !m_err) mem[m_idx] = m_wd;
      acc = hr && exp_ready();
      case (m_st)
         1: begin
            if (m_cnt == 0) m_st = m_err ? 2 : 0;
            else m_cnt--;
         end
         2: m_st = 3;
         default: begin
            if (acc) begin
               m_valid = s && t[1];
               m_write = w;
               m_err   = addr_err(a, w);
               m_idx   = (int'(a) >> 2) & 15;
               m_wd    = wd;
               if (m_valid) begin
                  if (WAITS > 0) begin m_st = 1; m_cnt = WAITS - 1; end
                  else m_st = m_err ? 2 : 0;
               end else m_st = 0;
            end else begin
               m_valid = 0;
               m_st = 0;
            end
         end
      endcase
   endtask

   task automatic step(input bit s, input logic [1:0] t, input bit w,
                       input logic [7:0] a, input logic [31:0] wd, input bit stl);
      bit hr;
      hr = exp_ready() && !stl;
      hsel = s; htrans = t; hwrite = w; haddr = a; hready = hr; hwdata = m_wd;
      d_sel = s; d_tr = t; d_wr = w; d_ad = a; d_wd = wd;
      model_step(s, t, w, a, wd, hr);
      @(negedge hclk);
      auto_check();
   endtask

   task automatic hold();
      step(d_sel, d_tr, d_wr, d_ad, d_wd, 1'b0);
   endtask

   task automatic idle();
      step(1'b0, 2'b00, 1'b0, 8'h00, 32'h0, 1'b0);
   endtask

   task automatic xfer(input bit w, input logic [7:0] a, input logic [31:0] wd);
      step(1'b1, 2'b10, w, a, wd, 1'b0);
      while (m_st == 1) hold();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(150000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

   initial begin
      int seed_v;
      seed_v = $urandom(32'd2024);
      for (int i = 0; i < 16; i++) mem[i] = (i < 4) ? PAT + 32'(i) : 32'h0;

      repeat (3) @(negedge hclk);
      // R1: response during reset
      chk("R1", {30'd0, hreadyout, hresp}, {30'd0, 1'b1, 1'b0});
      hresetn = 1'b1;
      @(negedge hclk);
      // R1: after release
      chk("R1", {30'd0, hreadyout, hresp}, {30'd0, 1'b1, 1'b0});
      chk("R1", hrdata, 32'h0);

      // R3, R12: write then read back, also through an alias
      step(1'b1, 2'b10, 1'b1, 8'h14, 32'h1111_2222, 1'b0);
      chk("R3", {30'd0, hreadyout, hresp}, 32'h0);
      while (m_st == 1) hold();
      xfer(1'b0, 8'h14, 32'h0);
      chk("R12", hrdata, 32'h1111_2222);
      xfer(1'b0, 8'h54, 32'h0);
      chk("R12", hrdata, 32'h1111_2222);

      // R7, R4, R5: write to a constant word
      xfer(1'b1, 8'h08, 32'hFFFF_FFFF);
      chk("R4", {30'd0, hreadyout, hresp}, {30'd0, 1'b0, 1'b1});
      step(1'b1, 2'b00, 1'b1, 8'h08, 32'h0, 1'b0);   // cancel to IDLE
      chk("R5", {30'd0, hreadyout, hresp}, {30'd0, 1'b1, 1'b1});
      xfer(1'b0, 8'h08, 32'h0);
      chk("R7", hrdata, PAT + 32'd2);

      // R6, R8, R11: read and write in the illegal band
      xfer(1'b0, 8'h2C, 32'h0);
      chk("R6", {31'd0, hresp}, 32'h1);
      chk("R8", hrdata, 32'h0);
      step(1'b0, 2'b00, 1'b0, 8'h00, 32'h0, 1'b0);
      chk("R8", hrdata, 32'h0);
      idle();
      chk("R11", {30'd0, hreadyout, hresp}, {30'd0, 1'b1, 1'b0});
      xfer(1'b1, 8'h28, 32'hDEAD_BEEF);
      chk("R6", {31'd0, hresp}, 32'h1);
      step(1'b1, 2'b00, 1'b0, 8'h00, 32'h0, 1'b0);
      xfer(1'b0, 8'h68, 32'h0);                       // same word, outside band
      chk("R8", hrdata, 32'h0);

      // R2: IDLE, BUSY and unselected writes do nothing
      step(1'b1, 2'b00, 1'b1, 8'h18, 32'h0BAD_0001, 1'b0);
      chk("R2", {30'd0, hreadyout, hresp}, {30'd0, 1'b1, 1'b0});
      step(1'b1, 2'b01, 1'b1, 8'h18, 32'h0BAD_0002, 1'b0);
      chk("R2", {30'd0, hreadyout, hresp}, {30'd0, 1'b1, 1'b0});
      step(1'b0, 2'b10, 1'b1, 8'h18, 32'h0BAD_0003, 1'b0);
      chk("R2", {30'd0, hreadyout, hresp}, {30'd0, 1'b1, 1'b0});
      idle();
      xfer(1'b0, 8'h18, 32'h0);
      chk("R2", hrdata, 32'h0);

      // R9: transfer presented while bus ready is low
      idle();
      step(1'b1, 2'b10, 1'b1, 8'h1C, 32'h5555_5555, 1'b1);
      chk("R9", {30'd0, hreadyout, hresp}, {30'd0, 1'b1, 1'b0});
      idle();
      xfer(1'b0, 8'h1C, 32'h0);
      chk("R9", hrdata, 32'h0);

      // R10, R11: manager continues through an error
      xfer(1'b1, 8'h28, 32'h1234_5678);
      step(1'b1, 2'b10, 1'b1, 8'h20, 32'hA1B2_C3D4, 1'b0);
      chk("R5", {30'd0, hreadyout, hresp}, {30'd0, 1'b1, 1'b1});
      hold();
      chk("R11", {31'd0, hresp}, 32'h0);
      while (m_st == 1) hold();
      xfer(1'b0, 8'h20, 32'h0);
      chk("R10", hrdata, 32'hA1B2_C3D4);

      // random traffic
      for (int n = 0; n < NRAND; n++) begin
         if (m_st == 1) begin
            hold();
         end else if (m_st == 2) begin
            if ($urandom % 2 == 0) step(d_sel, 2'b00, d_wr, d_ad, d_wd, 1'b0);
            else hold();
         end else begin
            bit          s, w, stl;
            logic [1:0]  t;
            logic [7:0]  a;
            int          r;
            s = ($urandom % 8) != 0;
            r = $urandom % 8;
            t = (r < 1) ? 2'b00 : (r < 2) ? 2'b01 : (r < 6) ? 2'b10 : 2'b11;
            w = $urandom % 2;
            case ($urandom % 4)
               0: a = 8'($urandom);
               1: a = 8'($urandom % 16);
               2: a = 8'h28 + 8'($urandom % 8);
               default: a = 8'h10 + 8'($urandom % 48);
            endcase
            stl = (m_st == 0) && !m_valid && (($urandom % 6) == 0);
            step(s, t, w, a, $urandom, stl);
         end
      end
      idle();
      finish_run();
   end

endmodule